// File: doc/BRIEF.md
# RAM-based multi-tap shift register

This block is a tapped delay line for w-bit samples. It has n taps, and the taps sit m accepted samples apart. The whole line is stored in a single memory array used as a circular buffer, not in a chain of flip-flops. Each memory word packs all n tap slots side by side.

On each accepted shift the block does three things in one clock:
- A ring pointer selects a word, and that word's old contents are read.
- The word is written back moved up by one slot. The oldest slot is dropped and the fresh sample goes into slot 0.
- The old contents are registered onto the tap outputs.

A longer line is made by feeding the last tap of one instance into the input of the next.

After a synchronous reset the block spends exactly m clocks writing zeros through every word. Shift requests are ignored during that time. After the clear pass, tap k reads zero until k·m samples have been shifted in.

The parameter set is checked when the design elaborates. The packed word must fit the data width of the chosen array class: 18 bits for the small class and 36 bits for the large one. The stored bits must also fit that class's capacity: 576 bits for the small class and 4,608 bits for the large one.

Top module: `ram_tap_delay`

## Requirements
- R1: A parameter set is accepted only if NUM_TAPS×DATA_W is at most 18 (small class, CFG=0) or 36 (large class, CFG=1), DATA_W×STAGE_LEN×NUM_TAPS is at most 576 (small) or 4,608 (large), NUM_TAPS ≥ 2 and STAGE_LEN ≥ 2. Elaboration rejects any other set. A large-class instance with a full 36-bit word shifts correctly.
- R2: While `rst` is high at a clock edge, all taps become zero. For the next STAGE_LEN clocks the memory is cleared, `shift_en` has no effect, and the taps stay zero.
- R3: The word pointer steps through 0…STAGE_LEN−1 and wraps to 0. It advances only on an accepted shift, meaning `shift_en` is high and no clear is in progress.
- R4: After the clock edge of an accepted shift, tap k (k = 1…NUM_TAPS, held in `taps[k·DATA_W−1 -: DATA_W]`) equals the `din` value accepted k·STAGE_LEN accepted shifts earlier.
- R5: When a clock edge carries no accepted shift, every tap keeps its value.
- R6: Tap k reads zero until more than k·STAGE_LEN shifts have been accepted since reset.
- R7: A shift completes in one clock. Back-to-back accepted shifts each update every tap with no stall.
- R8: When an instance's `din` is driven by the last tap of another instance on the same enable, the result is a longer delay line. Each of its taps follows R4, applied to the samples that arrived from the first instance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high; starts the clear pass |
| shift_en | input | 1 | Requests one shift of the whole line this cycle |
| din | input | DATA_W | New sample written into slot 0 |
| taps | output | NUM_TAPS×DATA_W | Registered tap values; tap k occupies bits [k·DATA_W−1 -: DATA_W] |

## Verification
Every accepted shift reads and rewrites the same memory word in the same clock. Each tap comparison therefore tests that the returned value is the word's old contents and not the sample being written.

A second collision happens when the last clear cycle meets a held-high `shift_en`. The bench raises the enable during reset and throughout the clear pass. It then expects the first shift exactly STAGE_LEN clocks after reset drops.

Random enable gaps make pointer wraps land on both stalled and active cycles. A reference line built from a sample history checks every tap on every clock.

// File: rtl/rtd_pkg.sv
package rtd_pkg;

   // Array class: selects the data-width and capacity limits
   typedef enum logic {
      RTD_CFG_SMALL = 1'b0,
      RTD_CFG_LARGE = 1'b1
   } rtd_cfg_e;

   function automatic int unsigned rtd_word_limit(rtd_cfg_e cfg);
      return (cfg == RTD_CFG_LARGE) ? 36 : 18;
   endfunction

   function automatic int unsigned rtd_bits_limit(rtd_cfg_e cfg);
      return (cfg == RTD_CFG_LARGE) ? 4608 : 576;
   endfunction

endpackage

// File: rtl/rtd_ring_ptr.sv
// Circular word pointer: 0 .. DEPTH-1, advances on adv only
module rtd_ring_ptr #(
   parameter int DEPTH = 8,
   parameter int PTR_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   output logic [PTR_W-1:0] ptr
);
   localparam bit               POW2 = (DEPTH == (1 << PTR_W));
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   generate
      if (POW2) begin : g_wrap_free
         // depth fills the pointer range: natural overflow wraps
         always_ff @(posedge clk) begin
            if (rst)
               ptr <= '0;
            else if (adv)
               ptr <= ptr + 1'b1;
         end
      end else begin : g_wrap_cmp
         always_ff @(posedge clk) begin
            if (rst)
               ptr <= '0;
            else if (adv)
               ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/rtd_clear_sweep.sv
// Post-reset pass writing zero to every word, one word per clock
module rtd_clear_sweep #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   output logic              busy,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b1;
         addr <= '0;
      end else if (busy) begin
         if (addr == LAST) begin
            busy <= 1'b0;
            addr <= '0;
         end else begin
            addr <= addr + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rtd_word_ram.sv
// Single array, asynchronous read port, synchronous write port.
// A read and a write to one address in the same cycle return old data.
module rtd_word_ram #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/rtd_slot_shift.sv
// Moves every slot up one position and inserts the fresh sample at slot 0
module rtd_slot_shift #(
   parameter int SLOT_W = 4,
   parameter int SLOTS  = 4
) (
   input  logic [(SLOTS-1)*SLOT_W-1:0] old_low,
   input  logic [SLOT_W-1:0]           din,
   output logic [SLOTS*SLOT_W-1:0]     new_word
);
   generate
      for (genvar j = 0; j < SLOTS; j++) begin : g_slot
         if (j == 0) begin : g_head
            assign new_word[SLOT_W-1:0] = din;
         end else begin : g_body
            assign new_word[j*SLOT_W +: SLOT_W] = old_low[(j-1)*SLOT_W +: SLOT_W];
         end
      end
   endgenerate
endmodule

// File: rtl/ram_tap_delay.sv
// Multi-tap delay line kept in one memory used as a circular buffer
module ram_tap_delay #(
   parameter int               DATA_W    = 4,
   parameter int               STAGE_LEN = 8,
   parameter int               NUM_TAPS  = 4,
   parameter rtd_pkg::rtd_cfg_e CFG      = rtd_pkg::RTD_CFG_SMALL
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       shift_en,
   input  logic [DATA_W-1:0]          din,
   output logic [NUM_TAPS*DATA_W-1:0] taps
);
   localparam int WORD_W   = NUM_TAPS * DATA_W;
   localparam int LOW_W    = (NUM_TAPS - 1) * DATA_W;
   localparam int PTR_W    = (STAGE_LEN > 1) ? $clog2(STAGE_LEN) : 1;
   localparam int BITS     = DATA_W * STAGE_LEN * NUM_TAPS;
   localparam int WORD_MAX = int'(rtd_pkg::rtd_word_limit(CFG));
   localparam int BITS_MAX = int'(rtd_pkg::rtd_bits_limit(CFG));

   // Elaboration-time parameter checks (R1)
   generate
      if (NUM_TAPS < 2) begin : g_bad_taps
         $error("ram_tap_delay: NUM_TAPS must be at least 2");
      end
      if (STAGE_LEN < 2) begin : g_bad_len
         $error("ram_tap_delay: STAGE_LEN must be at least 2");
      end
      if (WORD_W > WORD_MAX) begin : g_bad_word
         $error("ram_tap_delay: NUM_TAPS*DATA_W exceeds the array data width");
      end
      if (BITS > BITS_MAX) begin : g_bad_bits
         $error("ram_tap_delay: stored bits exceed the array capacity");
      end
   endgenerate

   logic              sweep_busy;
   logic [PTR_W-1:0]  sweep_addr;
   logic [PTR_W-1:0]  rd_ptr;
   logic              accept;
   logic              mem_we;
   logic [PTR_W-1:0]  mem_waddr;
   logic [WORD_W-1:0] mem_wdata;
   logic [WORD_W-1:0] old_word;
   logic [WORD_W-1:0] next_word;

   assign accept = shift_en & ~sweep_busy;

   rtd_clear_sweep #(
      .DEPTH (STAGE_LEN),
      .ADDR_W(PTR_W)
   ) u_sweep (
      .clk (clk),
      .rst (rst),
      .busy(sweep_busy),
      .addr(sweep_addr)
   );

   rtd_ring_ptr #(
      .DEPTH(STAGE_LEN),
      .PTR_W(PTR_W)
   ) u_ptr (
      .clk(clk),
      .rst(rst),
      .adv(accept),
      .ptr(rd_ptr)
   );

   rtd_slot_shift #(
      .SLOT_W(DATA_W),
      .SLOTS (NUM_TAPS)
   ) u_shift (
      .old_low (old_word[LOW_W-1:0]),
      .din     (din),
      .new_word(next_word)
   );

   // The clear pass owns the write port until it finishes
   assign mem_we    = sweep_busy | accept;
   assign mem_waddr = sweep_busy ? sweep_addr : rd_ptr;
   assign mem_wdata = sweep_busy ? '0 : next_word;

   rtd_word_ram #(
      .WORD_W(WORD_W),
      .DEPTH (STAGE_LEN),
      .ADDR_W(PTR_W)
   ) u_ram (
      .clk  (clk),
      .we   (mem_we),
      .waddr(mem_waddr),
      .wdata(mem_wdata),
      .raddr(rd_ptr),
      .rdata(old_word)
   );

   // Slot k-1 of the old word is the sample delayed k*STAGE_LEN shifts
   always_ff @(posedge clk) begin
      if (rst)
         taps <= '0;
      else if (accept)
         taps <= old_word;
   end
endmodule

// File: rtl/rtd_checker.sv
module rtd_checker #(
   parameter int DATA_W    = 4,
   parameter int STAGE_LEN = 8,
   parameter int NUM_TAPS  = 4,
   parameter int PTR_W     = 3
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       shift_en,
   input logic                       busy,
   input logic [PTR_W-1:0]           ptr,
   input logic [NUM_TAPS*DATA_W-1:0] taps
);
   AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      int'(ptr) < STAGE_LEN); // R3

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
      (shift_en && !busy) |=> int'(ptr) == ((int'($past(ptr)) + 1) % STAGE_LEN)); // R3

   AST_PTR_IDLE: assert property (@(posedge clk) disable iff (rst)
      !(shift_en && !busy) |=> $stable(ptr)); // R3

   AST_TAPS_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(shift_en && !busy) |=> $stable(taps)); // R5

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
      busy |-> taps == '0); // R2
endmodule

bind ram_tap_delay rtd_checker #(
   .DATA_W   (DATA_W),
   .STAGE_LEN(STAGE_LEN),
   .NUM_TAPS (NUM_TAPS),
   .PTR_W    (PTR_W)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .shift_en(shift_en),
   .busy    (sweep_busy),
   .ptr     (rd_ptr),
   .taps    (taps)
);

// File: tb/ram_tap_delay_test.sv
module ram_tap_delay_test;
   localparam int W  = 4;
   localparam int M1 = 8;
   localparam int N1 = 4;
   localparam int M2 = 4;
   localparam int N2 = 9;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic shift_en = 1'b0;
   logic [W-1:0] din = '0;
   logic [N1*W-1:0] taps1;
   logic [N2*W-1:0] taps2;

   always #5 clk = ~clk;

   ram_tap_delay #(
      .DATA_W(W), .STAGE_LEN(M1), .NUM_TAPS(N1), .CFG(rtd_pkg::RTD_CFG_SMALL)
   ) uut (
      .clk(clk), .rst(rst), .shift_en(shift_en), .din(din), .taps(taps1)
   );

   // Second line chained on the last tap, large class with a 36-bit word
   ram_tap_delay #(
      .DATA_W(W), .STAGE_LEN(M2), .NUM_TAPS(N2), .CFG(rtd_pkg::RTD_CFG_LARGE)
   ) uut_chain (
      .clk(clk), .rst(rst), .shift_en(shift_en), .din(taps1[N1*W-1 -: W]), .taps(taps2)
   );

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   // Reference: history of accepted samples per line
   logic [W-1:0] h1 [0:4095];
   logic [W-1:0] h2 [0:4095];
   int a1 = 0, a2 = 0, sw1 = 0, sw2 = 0;
   bit prev_acc = 1'b0;
   logic [N1*W-1:0] last1 = '0;
   logic [N2*W-1:0] last2 = '0;

   function automatic logic [W-1:0] ref1(int k);
      int idx = a1 - 1 - k * M1;
      return (idx >= 0) ? h1[idx] : '0;
   endfunction

   function automatic logic [W-1:0] ref2(int k);
      int idx = a2 - 1 - k * M2;
      return (idx >= 0) ? h2[idx] : '0;
   endfunction

   task automatic check(string tag, int k, logic [W-1:0] act, logic [W-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s tap %0d at %0t: got %h expected %h", tag, k, $time, act, exp);
      end
   endtask

   task automatic step(bit r, bit e, logic [W-1:0] d);
      logic [W-1:0] cin;
      bit acc1;
      rst      = r;
      shift_en = e;
      din      = d;
      cin      = ref1(N1);            // last tap seen by the chained line
      @(posedge clk);
      @(negedge clk);
      acc1 = !r && (sw1 == 0) && e;
      if (r) begin
         a1 = 0; a2 = 0; sw1 = M1; sw2 = M2;
      end else begin
         if (sw1 > 0) sw1--;
         else if (e) begin h1[a1] = d; a1++; end
         if (sw2 > 0) sw2--;
         else if (e) begin h2[a2] = cin; a2++; end
      end
      for (int k = 1; k <= N1; k++) begin
         logic [W-1:0] act;
         act = taps1[k*W-1 -: W];
         if (r || sw1 > 0)
            check("R2 clear", k, act, '0);
         else if (a1 - 1 - k * M1 < 0)
            check("R6 fill", k, act, ref1(k));
         else if (acc1 && prev_acc)
            check("R7 back-to-back", k, act, ref1(k));
         else
            check("R4 delay", k, act, ref1(k));
         if (!r && !acc1)
            check("R5 hold R3", k, act, last1[k*W-1 -: W]);
      end
      for (int k = 1; k <= N2; k++)
         check("R1 R8 chain", k, taps2[k*W-1 -: W], r ? '0 : ref2(k));
      last1    = taps1;
      last2    = taps2;
      prev_acc = acc1;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // R2: reset with enable held high, then the clear pass ignores it
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, W'($urandom));
      for (int i = 0; i < M1 + 4; i++) step(1'b0, 1'b1, W'($urandom));
      // Random enable gaps, pointer wraps on stalled and active cycles
      for (int i = 0; i < 600; i++) step(1'b0, ($urandom % 10) < 6, W'($urandom));
      // R7: unbroken burst
      for (int i = 0; i < 120; i++) step(1'b0, 1'b1, W'($urandom));
      // R5: long idle with changing data
      for (int i = 0; i < 25; i++) step(1'b0, 1'b0, W'($urandom));
      for (int i = 0; i < 300; i++) step(1'b0, ($urandom % 10) < 3, W'($urandom));
      // Reset in the middle of a filled line
      for (int i = 0; i < 2; i++) step(1'b1, 1'b0, W'($urandom));
      for (int i = 0; i < 500; i++) step(1'b0, ($urandom % 2) == 0, W'($urandom));
      for (int i = 0; i < 80; i++) step(1'b0, 1'b1, W'($urandom));
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule